// File: doc/BRIEF.md
# Infrared Transceiver Speed-Mode Programming Sequencer

This block sits on the controller side of an infrared link. It sets the receive bandwidth of an attached optical transceiver. The transceiver has no speed setting after power-up. It takes one from the level on its transmit-data pin at the moment its shared shutdown/mode pin falls. The sequencer drives both lines and produces that event with a setup window and a hold window around the falling edge. It then passes the host's serial transmit stream straight through to the transmit line.

The host gives a mode request (1 selects the high-bandwidth range of 0.576 to 4.0 Mbit/s, 0 selects the low-speed range up to 115.2 kbit/s) and a one-cycle start pulse. While the sequence runs, `busy_o` is high. `done_o` goes high once the transmit line is free for data. A shutdown request parks the transceiver with its shutdown/mode line high. On release, the sequence runs again on its own with the mode that was requested last. The setup and hold windows are parameters in nanoseconds. Each is converted to system clock cycles by rounding up, with a floor of one cycle.

Top module: `irx_mode_seq`

## Requirements
- R1: After reset, `sdm_o` is 1 and `txd_o`, `busy_o`, `done_o` and `mode_cur_o` are 0.
- R2: A start pulse taken while `busy_o` is 0 records `mode_req_i`. If `shdn_req_i` is 0, then on the following cycle `busy_o` is 1, `sdm_o` is 1 and `txd_o` carries the recorded mode level.
- R3: `sdm_o` stays 1 with `txd_o` at the mode level for exactly SETUP_CYC cycles, where SETUP_CYC = ceil(SETUP_NS*CLK_HZ/1e9) with a minimum of 1. After that, `sdm_o` falls.
- R4: After the fall, `txd_o` holds the mode level for exactly HOLD_CYC cycles (computed like SETUP_CYC from HOLD_NS) while `sdm_o` is 0 and `busy_o` is 1.
- R5: After the hold window, `busy_o` is 0, `done_o` is 1, and `txd_o` follows `host_txd_i` within the same cycle.
- R6: `mode_cur_o` takes the `txd_o` level present in the cycle `sdm_o` falls and keeps it until the next such fall.
- R7: While `busy_o` is 1, start pulses are ignored (no mode is recorded), and `txd_o` stays constant whatever `host_txd_i` does.
- R8: `done_o` is 0 whenever `sdm_o` is 1 and during the whole sequence.
- R9: `shdn_req_i` at 1 aborts any sequence. From the next cycle, for as long as the request is held, `sdm_o` is 1 and `txd_o`, `busy_o` and `done_o` are 0.
- R10: When `shdn_req_i` returns to 0 and a mode has been recorded, the sequence reruns with the last recorded mode without a new start. With no recorded mode, the block stays in shutdown.
- R11: A start pulse in the same cycle as `shdn_req_i` is recorded (when not busy), but shutdown takes precedence. The recorded mode is then programmed on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to program a mode |
| mode_req_i | input | 1 | Requested mode: 1 high bandwidth, 0 low speed |
| shdn_req_i | input | 1 | Hold transceiver in shutdown while 1 |
| host_txd_i | input | 1 | Host serial transmit data |
| sdm_o | output | 1 | Shared shutdown/mode line to the transceiver |
| txd_o | output | 1 | Transmit line to the transceiver |
| busy_o | output | 1 | Programming sequence in progress |
| done_o | output | 1 | Mode programmed, data path open |
| mode_cur_o | output | 1 | Mode last latched by the transceiver |

## Verification
A start pulse and a shutdown request can arrive in the same cycle. In that case shutdown must win the line state, and the mode must still be recorded for the rerun on release. The bench drives both on one clock edge. It checks that the lines stay parked in shutdown and that, after release, the latched mode equals the one that came with the start pulse. The bench also starts a sequence in mid-flight and toggles host data during the setup and hold windows. A behavioural reference is compared against every output on every clock.

// File: rtl/irx_pkg.sv
package irx_pkg;

  typedef enum logic [1:0] {
    ST_SHDN  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HOLD  = 2'd2,
    ST_READY = 2'd3
  } irx_state_e;

  // Round a time in ns up to whole clock cycles; never below one cycle.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned hz);
    longint unsigned num;
    longint unsigned cyc;
    num = 64'(ns) * 64'(hz);
    cyc = (num + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return cyc[31:0];
  endfunction

  // Counter width able to hold the larger of two cycle counts.
  function automatic int unsigned win_width(input int unsigned a,
                                            input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/irx_win_timer.sv
module irx_win_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] lim,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign expire = (cnt_q == (lim - 1'b1));
endmodule

// File: rtl/irx_req_hold.sv
module irx_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic mode_in,
  output logic mode_q,
  output logic have_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      have_q <= 1'b0;
    end else if (take) begin
      mode_q <= mode_in;
      have_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irx_txd_sel.sv
module irx_txd_sel (
  input  logic cfg_en,
  input  logic pass_en,
  input  logic cfg_lvl,
  input  logic host,
  output logic txd
);
  always_comb begin
    if (pass_en)     txd = host;
    else if (cfg_en) txd = cfg_lvl;
    else             txd = 1'b0;
  end
endmodule

// File: rtl/irx_mode_seq.sv
module irx_mode_seq
  import irx_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned SETUP_NS = 200,
  parameter int unsigned HOLD_NS  = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mode_req_i,
  input  logic shdn_req_i,
  input  logic host_txd_i,
  output logic sdm_o,
  output logic txd_o,
  output logic busy_o,
  output logic done_o,
  output logic mode_cur_o
);
  localparam int unsigned SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_HZ);
  localparam int unsigned HOLD_CYC  = ns_to_cycles(HOLD_NS, CLK_HZ);
  localparam int unsigned CW        = win_width(SETUP_CYC, HOLD_CYC);
  localparam logic [CW-1:0] SETUP_LIM = CW'(SETUP_CYC);
  localparam logic [CW-1:0] HOLD_LIM  = CW'(HOLD_CYC);

  irx_state_e state_q, state_d;

  // Named internal events
  logic acc_start;
  logic tmr_exp;
  logic tmr_restart;
  logic latch_evt;
  logic req_mode;
  logic req_have;
  logic [CW-1:0] win_lim;
  logic mode_cur_q;

  assign busy_o    = (state_q == ST_SETUP) || (state_q == ST_HOLD);
  assign acc_start = start_i && !busy_o;

  irx_req_hold u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (acc_start),
    .mode_in (mode_req_i),
    .mode_q  (req_mode),
    .have_q  (req_have)
  );

  always_comb begin
    state_d = state_q;
    if (shdn_req_i) begin
      state_d = ST_SHDN;
    end else begin
      unique case (state_q)
        ST_SHDN:  if (req_have || acc_start) state_d = ST_SETUP;
        ST_SETUP: if (tmr_exp)               state_d = ST_HOLD;
        ST_HOLD:  if (tmr_exp)               state_d = ST_READY;
        ST_READY: if (acc_start)             state_d = ST_SETUP;
        default:                             state_d = ST_SHDN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SHDN;
    else        state_q <= state_d;
  end

  assign tmr_restart = (state_d != state_q);
  assign win_lim     = (state_q == ST_HOLD) ? HOLD_LIM : SETUP_LIM;

  irx_win_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .lim     (win_lim),
    .expire  (tmr_exp)
  );

  // The mode line falls exactly when SETUP hands over to HOLD.
  assign latch_evt = (state_q == ST_SETUP) && (state_d == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_cur_q <= 1'b0;
    else if (latch_evt) mode_cur_q <= req_mode;
  end

  irx_txd_sel u_sel (
    .cfg_en  (busy_o),
    .pass_en (state_q == ST_READY),
    .cfg_lvl (req_mode),
    .host    (host_txd_i),
    .txd     (txd_o)
  );

  assign sdm_o      = (state_q == ST_SHDN) || (state_q == ST_SETUP);
  assign done_o     = (state_q == ST_READY);
  assign mode_cur_o = mode_cur_q;
endmodule

// File: rtl/irx_mode_seq_chk.sv
module irx_mode_seq_chk #(
  parameter int unsigned SETUP_CYC = 10,
  parameter int unsigned HOLD_CYC  = 10
) (
  input logic clk,
  input logic rst_n,
  input logic shdn_req_i,
  input logic sdm_o,
  input logic txd_o,
  input logic busy_o,
  input logic done_o,
  input logic mode_cur_o
);
  logic [15:0] setcnt, holdcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setcnt  <= '0;
      holdcnt <= '0;
    end else begin
      if (busy_o && sdm_o) begin
        if (setcnt != '1) setcnt <= setcnt + 1'b1;
      end else setcnt <= '0;
      if (busy_o && !sdm_o) begin
        if (holdcnt != '1) holdcnt <= holdcnt + 1'b1;
      end else holdcnt <= '0;
    end
  end

  a_r3_setup_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdm_o) |-> (setcnt >= 16'(SETUP_CYC)));

  a_r4_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (holdcnt >= 16'(HOLD_CYC)));

  a_r3_fall_in_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdm_o) |-> (busy_o && $stable(txd_o)));

  a_r6_latched_level: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdm_o) |-> (mode_cur_o == txd_o));

  a_r7_txd_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(txd_o));

  a_r8_no_done_sdm_high: assert property (@(posedge clk) disable iff (!rst_n)
    sdm_o |-> !done_o);

  a_r9_shutdown_park: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_req_i |=> (sdm_o && !txd_o && !busy_o && !done_o));
endmodule

bind irx_mode_seq irx_mode_seq_chk #(
  .SETUP_CYC (SETUP_CYC),
  .HOLD_CYC  (HOLD_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shdn_req_i (shdn_req_i),
  .sdm_o      (sdm_o),
  .txd_o      (txd_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mode_cur_o (mode_cur_o)
);

// File: tb/sim_irx_mode_seq.sv
module sim_irx_mode_seq;
  localparam int unsigned CLK_HZ = 50_000_000;
  localparam int SET_NS = 200;
  localparam int HLD_NS = 200;
  // Own restatement: cycles = ceil(ns * MHz / 1000)
  localparam int SC = (SET_NS * (CLK_HZ / 1_000_000) + 999) / 1000;
  localparam int HC = (HLD_NS * (CLK_HZ / 1_000_000) + 999) / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mreq = 1'b0, shdn = 1'b0, host = 1'b0;
  logic sdm, txd, busy, done, mcur;

  irx_mode_seq #(.CLK_HZ(CLK_HZ), .SETUP_NS(SET_NS), .HOLD_NS(HLD_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_req_i(mreq),
    .shdn_req_i(shdn), .host_txd_i(host), .sdm_o(sdm), .txd_o(txd),
    .busy_o(busy), .done_o(done), .mode_cur_o(mcur));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // Reference model: phase 0 parked, 1 setup, 2 hold, 3 ready
  int ph = 0, left = 0;
  bit rm = 0, have = 0, mc = 0;

  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      ph = 0; left = 0; rm = 0; have = 0; mc = 0;
    end else begin
      acc = start && !(ph == 1 || ph == 2);
      if (acc) begin rm = mreq; have = 1; end
      if (shdn) ph = 0;
      else if (ph == 0) begin
        if (have) begin ph = 1; left = SC; end
      end else if (ph == 1) begin
        left--;
        if (left == 0) begin ph = 2; left = HC; mc = rm; end
      end else if (ph == 2) begin
        left--;
        if (left == 0) ph = 3;
      end else if (acc) begin
        ph = 1; left = SC;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp,
                     input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int e_sdm, e_txd, e_busy, e_done;
    #5;
    if (rst_n && !finished) begin
      e_sdm  = (ph == 0 || ph == 1);
      e_busy = (ph == 1 || ph == 2);
      e_done = (ph == 3);
      e_txd  = (ph == 3) ? int'(host) : ((ph == 0) ? 0 : int'(rm));
      chk(sdm == e_sdm,   "R3", sdm,  e_sdm,  "model sdm");
      chk(busy == e_busy, "R4", busy, e_busy, "model busy");
      chk(txd == e_txd,   "R7", txd,  e_txd,  "model txd");
      chk(done == e_done, "R8", done, e_done, "model done");
      chk(mcur == mc,     "R6", mcur, mc,     "model mode");
    end
  end

  task automatic pulse_start(input bit m);
    @(negedge clk); start = 1'b1; mreq = m;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sdm == 1 && txd == 0 && busy == 0 && done == 0 && mcur == 0,
        "R1", {sdm, txd, busy, done, mcur}, 5'b10000, "reset outputs");
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(sdm == 1 && done == 0, "R10", {sdm, done}, 2'b10, "no request stays parked");

    // R2 start high bandwidth
    pulse_start(1'b1);
    chk(busy == 1 && sdm == 1 && txd == 1, "R2", {busy, sdm, txd}, 3'b111, "sequence entry");
    host = 1'b1;                                   // R7: host toggles while busy
    repeat (SC - 1) @(negedge clk);
    chk(sdm == 1, "R3", sdm, 1, "last setup cycle");
    @(negedge clk);
    chk(sdm == 0 && txd == 1 && busy == 1, "R4", {sdm, txd, busy}, 3'b011, "hold entry");
    host = 1'b0;
    wait_done();
    chk(mcur == 1, "R6", mcur, 1, "high mode latched");
    host = 1'b1; #1;
    chk(txd == 1, "R5", txd, 1, "pass-through high");
    host = 1'b0; #1;
    chk(txd == 0, "R5", txd, 0, "pass-through low");

    // R7 start while busy ignored
    pulse_start(1'b0);
    repeat (3) @(negedge clk);
    pulse_start(1'b1);
    host = 1'b1;
    wait_done();
    host = 1'b0;
    chk(mcur == 0, "R7", mcur, 0, "busy start ignored");

    // R9 shutdown in hold window, R10 rerun with last mode
    pulse_start(1'b1);
    repeat (SC + 2) @(negedge clk);
    shdn = 1'b1;
    @(negedge clk);
    chk(sdm == 1 && txd == 0 && busy == 0 && done == 0, "R9",
        {sdm, txd, busy, done}, 4'b1000, "abort to shutdown");
    repeat (6) @(negedge clk);
    chk(sdm == 1 && busy == 0, "R9", {sdm, busy}, 2'b10, "shutdown held");
    shdn = 1'b0;
    @(negedge clk);
    chk(busy == 1 && txd == 1, "R10", {busy, txd}, 2'b11, "rerun on release");
    wait_done();
    chk(mcur == 1 && done == 1, "R10", {mcur, done}, 2'b11, "rerun mode");

    // R11 start and shutdown in the same cycle
    @(negedge clk); shdn = 1'b1; start = 1'b1; mreq = 1'b0;
    @(negedge clk); start = 1'b0;
    chk(sdm == 1 && busy == 0 && done == 0, "R11", {sdm, busy, done}, 3'b100, "shutdown wins");
    repeat (4) @(negedge clk);
    shdn = 1'b0;
    wait_done();
    chk(mcur == 0 && done == 1, "R11", {mcur, done}, 2'b01, "recorded mode programmed");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule